// File: doc/BRIEF.md
# General-Purpose I/O Bank with Edge Capture

This block drives and samples one bank of up to 32 general-purpose pins through a small word-addressed register bus. Software selects the direction of each pin and changes output levels by writing bit masks to a set address or a clear address. Neither write needs a read-modify-write. The bank reads back the live level of every pin, whether the pin is an input or an output.

Each pin can also record rising transitions, falling transitions or both into a sticky status word. An interrupt line stays high while any status bit is pending. Software clears pending bits by writing ones to the status address. Pin inputs pass through a two-flop synchroniser before they are used anywhere, so the pads may change at any time.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, the direction, output, rising-enable, falling-enable and status registers are all zero, `pad_oe` and `pad_out` are zero, and `irq` is low.
- R2: A write to address 2 (set) makes every output bit high where the written bit is 1 and leaves the other output bits unchanged. Address 2 reads as zero.
- R3: A write to address 3 (clear) makes every output bit low where the written bit is 1 and leaves the other output bits unchanged. Address 3 reads as zero.
- R4: Address 0 reads the pin levels after a two-flop synchroniser, for inputs and outputs alike. Writes to address 0 have no effect.
- R5: Address 1 holds the direction. Bit n set to 1 drives pin n (`pad_oe[n]`=1) and bit n at 0 makes it an input. The register reads back what was written and changes only when address 1 is written.
- R6: Address 4 holds the rising-edge enables and address 5 the falling-edge enables. A status bit becomes 1 when its synchronised pin goes 0 to 1 with its rising enable set, or 1 to 0 with its falling enable set. With both enables clear, the pin records nothing.
- R7: Address 6 reads the status. Writing 1 to a bit clears it, and writing 0 leaves it alone. If a new enabled edge on a bit coincides with a clear of that bit, the bit stays 1.
- R8: `irq` is the OR of all status bits, registered once. It rises in the cycle after a status bit sets and falls in the cycle after the last bit clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| bus_addr | input | 3 | Word address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | PINS (32) | Pad input levels, asynchronous |
| pad_out | output | PINS (32) | Output levels to the pads |
| pad_oe | output | PINS (32) | Output enables to the pads |
| irq | output | 1 | Pending-edge interrupt |

## Verification
A corrupted output or direction bit shows on `pad_out` or `pad_oe` in the cycle after the write. Through a looped-back pad, it reaches the level readback two cycles later. A status bit that sets wrongly or fails to clear reaches `irq` one clock after the status flop. Status readback shows it at once, so edge-capture faults appear within four clocks of the pad change. The test that pits a clear against an edge in the same cycle exposes a wrong priority between the two as a bit that is missing from status.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned BANK_ADDR_W = 3;

  typedef enum logic [BANK_ADDR_W-1:0] {
    SEL_LEVEL = 3'd0,
    SEL_DIR   = 3'd1,
    SEL_SET   = 3'd2,
    SEL_CLR   = 3'd3,
    SEL_RISE  = 3'd4,
    SEL_FALL  = 3'd5,
    SEL_STAT  = 3'd6,
    SEL_NONE  = 3'd7
  } bank_sel_e;

  localparam int unsigned BANK_NSEL = 2 ** BANK_ADDR_W;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  localparam int unsigned NST = (STAGES < 2) ? 2 : STAGES;

  logic [W-1:0] chain_q [NST];

  generate
    for (genvar s = 0; s < NST; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = async_in;
      end else begin : g_rest
        assign stage_d = chain_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= stage_d;
      end
    end
  endgenerate

  assign sync_out = chain_q[NST-1];

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_we,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic         rise_we,
  input  logic         fall_we,
  input  logic [W-1:0] wmask,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] out_q,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] fall_q
);

  logic [W-1:0] dir_d, out_d, rise_d, fall_d;
  logic         out_en;

  always_comb begin
    dir_d  = dir_we  ? wmask : dir_q;
    rise_d = rise_we ? wmask : rise_q;
    fall_d = fall_we ? wmask : fall_q;
    out_en = set_we | clr_we;
    out_d  = out_q;
    if (set_we) out_d = out_q | wmask;
    else if (clr_we) out_d = out_q & ~wmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      if (dir_we)  dir_q  <= dir_d;
      if (out_en)  out_q  <= out_d;
      if (rise_we) rise_q <= rise_d;
      if (fall_we) fall_q <= fall_d;
    end
  end

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_we |=> $stable(dir_q)); // R5
  AST_SET_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((out_q & $past(wmask)) == $past(wmask))); // R2
  AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> (((out_q ^ $past(out_q)) & ~$past(wmask)) == '0)); // R2
  AST_CLR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((out_q & $past(wmask)) == '0)); // R3
  AST_CLR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> (((out_q ^ $past(out_q)) & ~$past(wmask)) == '0)); // R3

endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic         ack_we,
  input  logic [W-1:0] ack_mask,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] hit
);

  logic [W-1:0] prev_q;
  logic [W-1:0] went_up, went_down;
  logic [W-1:0] ack_bits;
  logic [W-1:0] stat_d;
  logic         stat_en;

  always_comb begin
    went_up   = level & ~prev_q;
    went_down = ~level & prev_q;
    hit       = (went_up & rise_en) | (went_down & fall_en);
    ack_bits  = ack_we ? ack_mask : '0;
    // a fresh edge outranks a clear in the same cycle
    stat_d    = (stat_q & ~ack_bits) | hit;
    stat_en   = (|ack_bits) | (|hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= level;
      if (stat_en) stat_q <= stat_d;
    end
  end

  AST_HIT_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (($past(hit) & ~stat_q) == '0)); // R7
  AST_ONLY_ENABLED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((stat_q & ~$past(stat_q) & ~$past(rise_en | fall_en)) == '0)); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> (($past(stat_q & ack_mask & ~hit) & stat_q) == '0)); // R7

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PINS   = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [BANK_ADDR_W-1:0] bus_addr,
  input  logic                   bus_we,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [PINS-1:0]        pad_in,
  output logic [PINS-1:0]        pad_out,
  output logic [PINS-1:0]        pad_oe,
  output logic                   irq
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [BANK_NSEL-1:0] wr_stb;
  logic [PINS-1:0]      wmask;
  logic [PINS-1:0]      lvl_sync;
  logic [PINS-1:0]      dir_q, out_q, rise_q, fall_q;
  logic [PINS-1:0]      stat_q, hit;
  logic                 irq_d;

  always_comb begin
    wr_stb = '0;
    if (bus_we) wr_stb[bus_addr] = 1'b1;
    wmask = bus_wdata[PINS-1:0];
  end

  gpio_in_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (lvl_sync)
  );

  gpio_ctrl_regs #(.W(PINS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .dir_we  (wr_stb[SEL_DIR]),
    .set_we  (wr_stb[SEL_SET]),
    .clr_we  (wr_stb[SEL_CLR]),
    .rise_we (wr_stb[SEL_RISE]),
    .fall_we (wr_stb[SEL_FALL]),
    .wmask   (wmask),
    .dir_q   (dir_q),
    .out_q   (out_q),
    .rise_q  (rise_q),
    .fall_q  (fall_q)
  );

  gpio_edge_status #(.W(PINS)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (lvl_sync),
    .rise_en  (rise_q),
    .fall_en  (fall_q),
    .ack_we   (wr_stb[SEL_STAT]),
    .ack_mask (wmask),
    .stat_q   (stat_q),
    .hit      (hit)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bank_sel_e'(bus_addr))
      SEL_LEVEL: bus_rdata[PINS-1:0] = lvl_sync;
      SEL_DIR:   bus_rdata[PINS-1:0] = dir_q;
      SEL_RISE:  bus_rdata[PINS-1:0] = rise_q;
      SEL_FALL:  bus_rdata[PINS-1:0] = fall_q;
      SEL_STAT:  bus_rdata[PINS-1:0] = stat_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq_d = |stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;

  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q != '0) |=> irq); // R8
  AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == '0) |=> !irq); // R8
  AST_IDLE_NO_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_q | fall_q) == '0 && stat_q == '0) |=> (stat_q == '0)); // R6

endmodule

// File: tb/gpio_edge_bank_tb.sv
`timescale 1ns/1ps
module gpio_edge_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in, pad_out, pad_oe;
  logic [31:0] ext = '0;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  // pads loop back what they drive; inputs come from ext
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_edge_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // {is_write, addr, data_or_expected, req}
  localparam int NV = 16;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 3'd1, 32'h0000_FFFF, 4'd5},  // R5 dir low half out
    {1'b0, 3'd1, 32'h0000_FFFF, 4'd5},  // R5 readback
    {1'b1, 3'd2, 32'hA5A5_A5A5, 4'd2},  // R2 set
    {1'b0, 3'd0, 32'h0000_A5A5, 4'd4},  // R4 level of outputs
    {1'b0, 3'd2, 32'h0000_0000, 4'd2},  // R2 set reads zero
    {1'b1, 3'd3, 32'h0000_00F0, 4'd3},  // R3 clear
    {1'b0, 3'd0, 32'h0000_A505, 4'd3},  // R3 others kept
    {1'b0, 3'd3, 32'h0000_0000, 4'd3},  // R3 clear reads zero
    {1'b1, 3'd0, 32'hFFFF_FFFF, 4'd4},  // R4 write ignored
    {1'b0, 3'd0, 32'h0000_A505, 4'd4},  // R4
    {1'b1, 3'd1, 32'hFFFF_FFFF, 4'd5},  // R5 all out
    {1'b0, 3'd0, 32'hA5A5_A505, 4'd2},  // R2 upper bits held
    {1'b1, 3'd3, 32'hFFFF_FFFF, 4'd3},  // R3 clear all
    {1'b0, 3'd0, 32'h0000_0000, 4'd3},  // R3
    {1'b1, 3'd1, 32'h0000_0000, 4'd5},  // R5 back to inputs
    {1'b0, 3'd6, 32'h0000_0000, 4'd6}   // R6 no enables, no status
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 v = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 oe", pad_oe, 32'd0);
    check("R1 out", pad_out, 32'd0);
    for (int a = 1; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 regs", v, 32'd0);
    end

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][39]) wr(VEC[i][38:36], VEC[i][35:4]);
      else begin
        idle(3);
        rd(VEC[i][38:36], v);
        check($sformatf("R%0d vec%0d", VEC[i][3:0], i), v, VEC[i][35:4]);
      end
    end
    check("R5 oe after table", pad_oe, 32'd0);

    // R6 rising edge on pin 3
    wr(3'd4, 32'h0000_0008);
    ext[3] = 1'b1;
    idle(5);
    rd(3'd6, v); check("R6 rise", v, 32'h0000_0008);
    check("R8 irq up", {31'd0, irq}, 32'd1);
    // R7 writing 0 keeps
    wr(3'd6, 32'hFFFF_FFF7);
    rd(3'd6, v); check("R7 zero keeps", v, 32'h0000_0008);
    // R6 falling with only rise enabled: nothing new; R7 clear
    wr(3'd6, 32'h0000_0008);
    check("R8 irq lags", {31'd0, irq}, 32'd1);
    @(negedge clk);
    check("R8 irq down", {31'd0, irq}, 32'd0);
    ext[3] = 1'b0;
    idle(5);
    rd(3'd6, v); check("R6 fall ignored", v, 32'd0);

    // R6 falling enable on pin 7
    wr(3'd5, 32'h0000_0080);
    ext[7] = 1'b1; idle(5);
    rd(3'd6, v); check("R6 no rise on fall-only", v, 32'd0);
    ext[7] = 1'b0; idle(5);
    rd(3'd6, v); check("R6 fall", v, 32'h0000_0080);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, v); check("R7 all ones", v, 32'd0);

    // R6 pin 9 with no enable toggles
    ext[9] = 1'b1; idle(5); ext[9] = 1'b0; idle(5);
    rd(3'd6, v); check("R6 disabled pin", v, 32'd0);
    check("R8 quiet", {31'd0, irq}, 32'd0);

    // R7 edge and clear in the same cycle on pin 3
    wr(3'd5, 32'h0000_0008);
    ext[3] = 1'b1; idle(5);
    rd(3'd6, v); check("R7 pre", v, 32'h0000_0008);
    @(negedge clk) ext[3] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 3'd6; bus_we = 1'b1; bus_wdata = 32'h0000_0008;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
    rd(3'd6, v); check("R7 edge wins", v, 32'h0000_0008);
    wr(3'd6, 32'h0000_0008);
    rd(3'd6, v); check("R7 cleared", v, 32'd0);

    // R1 reset mid-run
    wr(3'd1, 32'h0000_0001);
    wr(3'd2, 32'h0000_0001);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R1 oe reset", pad_oe, 32'd0);
    check("R1 out reset", pad_out, 32'd0);
    rst_n = 1'b1;
    rd(3'd4, v); check("R1 rise reset", v, 32'd0);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule